// File: doc/BRIEF.md
# Power-Management Timer with Event Status and Enable Registers

This block keeps a free-running power-management timer and a pair of 16-bit event registers. One register holds latched status flags and the other holds the matching enables. Together they drive a level-sensitive system control interrupt line. The timer advances at a fixed fraction of the system clock rate. A phase accumulator produces that rate: it adds a constant scale every clock, and each carry out of its fractional part moves the count by one. Whenever the timer's top bit changes value, in either direction, the timer status flag latches.

A host reaches the registers through a byte-addressed port with 1-, 2- or 4-byte accesses. The event window spans four byte addresses: status in the low two bytes, enable in the high two bytes. The timer is a separate read-only word at its own address. Status flags clear when a one is written to them. Test inputs can raise the power-button and global status flags. The interrupt line is high whenever an enabled status flag among the three interrupt sources is set.

Top module: `pmtick_sci_top`

## Requirements
- R1: After reset the timer, status and enable registers read zero and `sci` is low.
- R2: The timer advances only by the carries of a 32-bit fractional accumulator that adds scale = (TMR_HZ·2^32)/REF_HZ each clock. With TMR_HZ equal to half of REF_HZ it gains exactly N/2 over any N consecutive clocks, and it wraps modulo 2^TMR_W.
- R3: Whenever the timer's most significant bit changes, status bit 0 (timer flag) is set in the same cycle. The first such change comes when the count reaches 2^(TMR_W-1), and the wrap back to zero is another.
- R4: Status is write-one-to-clear per byte lane. A byte at event offset 0 clears status bits 7:0 where it holds ones, and a byte at offset 1 clears bits 15:8. Zero bits leave the flags unchanged. Only status bits 0, 5 and 8 can ever read as one.
- R5: The enable register is written per byte lane: offset 2 writes bits 7:0 and offset 3 writes bits 15:8. The other lane keeps its value.
- R6: A multi-byte write at event offset o is applied as single bytes to offsets o, o+1, …. Byte i comes from write data bits 8i+7:8i, and bytes that would fall past offset 3 are dropped.
- R7: A read at event offset o returns ({enable, status} >> 8·o), masked to 8 bits for size code 0 and to 16 bits for size code 1. Size codes 2 and 3 both mean a 4-byte access.
- R8: The timer word is read-only. Writes to it change nothing, and a timer read of any size other than 4 bytes returns zero.
- R9: `sci` is high exactly when (enable & status & 0x0121) is nonzero. An enable bit outside 0, 5 and 8 never raises it.
- R10: `set_pwrbtn` sets status bit 5 and `set_global` sets status bit 8. A set wins over a clear of the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| bus_wdata | input | 32 | Write data, first byte in bits 7:0 |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read request |
| set_pwrbtn | input | 1 | Sets power-button status flag |
| set_global | input | 1 | Sets global status flag |
| sci | output | 1 | Level system control interrupt |

## Verification
The assertions assume that reset is held for at least one clock and that TMR_HZ does not exceed REF_HZ, so the timer moves by at most one count per clock. They also take bus requests to be single-cycle and to carry a size code. The bench drives every request for exactly one cycle from the falling edge and uses a 10-bit timer at half the clock rate, so both top-bit transitions fall within a few thousand cycles. The bench also applies a fresh reset before each scenario, so the timer flag cannot latch in the middle of a status check unless the scenario intends it.

// File: rtl/pmtick_pkg.sv
package pmtick_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    localparam int EVT_W   = 16;
    localparam int BIT_TMR = 0;
    localparam int BIT_PWR = 5;
    localparam int BIT_GBL = 8;

    localparam logic [EVT_W-1:0] SCI_SRC_MASK =
        EVT_W'((1 << BIT_TMR) | (1 << BIT_PWR) | (1 << BIT_GBL));

    typedef struct packed {
        logic [EVT_W-1:0] en;
        logic [EVT_W-1:0] sts;
    } evt_state_t;

    function automatic logic [2:0] size_bytes(input acc_size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/pmtick_rate_gen.sv
module pmtick_rate_gen #(
    parameter int          TMR_W = 32,
    parameter logic [63:0] SCALE = 64'h0000_0000_1253_0A78
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [TMR_W-1:0] count_o,
    output logic             msb_flip_o
);
    localparam int               FRAC_W    = 32;
    localparam logic [FRAC_W-1:0] FRAC_STEP = SCALE[FRAC_W-1:0];
    localparam logic [TMR_W-1:0]  INT_STEP  = TMR_W'(SCALE >> FRAC_W);

    typedef struct packed {
        logic [FRAC_W-1:0] frac;
        logic [TMR_W-1:0]  cnt;
    } rate_state_t;

    rate_state_t st_d, st_q;
    logic [FRAC_W:0] sum_d;

    always_comb begin
        sum_d      = {1'b0, st_q.frac} + {1'b0, FRAC_STEP};
        st_d.frac  = sum_d[FRAC_W-1:0];
        st_d.cnt   = st_q.cnt + INT_STEP + TMR_W'(sum_d[FRAC_W]);
        msb_flip_o = st_d.cnt[TMR_W-1] != st_q.cnt[TMR_W-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;

    // R2: the count only ever moves by the integer step or one more
    p_step_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((count_o - $past(count_o)) == INT_STEP) ||
        ((count_o - $past(count_o)) == INT_STEP + TMR_W'(1)));

endmodule

// File: rtl/pmtick_port.sv
module pmtick_port
    import pmtick_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] EVT_BASE = 16'h0400,
    parameter logic [ADDR_W-1:0] TMR_BASE = 16'h0408
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [3:0]        lane_we,
    output logic [31:0]       lane_wd,
    output logic              evt_rd_hit,
    output logic [1:0]        evt_off,
    output logic              tmr_rd_hit
);
    localparam int LANES = 4;

    logic [ADDR_W-1:0] delta;
    logic              evt_hit;
    logic [2:0]        nbytes;
    acc_size_e         sz;

    always_comb begin
        sz         = acc_size_e'(bus_size);
        delta      = bus_addr - EVT_BASE;
        evt_hit    = delta < ADDR_W'(LANES);
        evt_off    = delta[1:0];
        nbytes     = size_bytes(sz);
        evt_rd_hit = bus_valid && !bus_write && evt_hit;
        tmr_rd_hit = bus_valid && !bus_write && (bus_addr == TMR_BASE) &&
                     (nbytes == 3'd4);
    end

    for (genvar L = 0; L < LANES; L++) begin : g_lane
        logic [2:0]  rel;
        logic [31:0] shifted;
        always_comb begin
            rel        = 3'(L) - {1'b0, evt_off};
            shifted    = bus_wdata >> {rel, 3'b000};
            lane_we[L] = bus_valid && bus_write && evt_hit &&
                         ({1'b0, evt_off} <= 3'(L)) && (rel < nbytes);
            lane_wd[8*L +: 8] = shifted[7:0];
        end
    end

endmodule

// File: rtl/pmtick_event_regs.sv
module pmtick_event_regs
    import pmtick_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       lane_we,
    input  logic [31:0]      lane_wd,
    input  logic             set_tmr,
    input  logic             set_pwr,
    input  logic             set_gbl,
    output logic [EVT_W-1:0] sts_o,
    output logic [EVT_W-1:0] en_o,
    output logic             sci_o
);
    evt_state_t ev_d, ev_q;

    always_comb begin
        ev_d = ev_q;
        // status lanes: write-one-to-clear
        if (lane_we[0]) ev_d.sts[7:0]  = ev_q.sts[7:0]  & ~lane_wd[7:0];
        if (lane_we[1]) ev_d.sts[15:8] = ev_q.sts[15:8] & ~lane_wd[15:8];
        // enable lanes: plain byte writes
        if (lane_we[2]) ev_d.en[7:0]   = lane_wd[23:16];
        if (lane_we[3]) ev_d.en[15:8]  = lane_wd[31:24];
        // sources last so a same-cycle set beats a clear
        if (set_tmr) ev_d.sts[BIT_TMR] = 1'b1;
        if (set_pwr) ev_d.sts[BIT_PWR] = 1'b1;
        if (set_gbl) ev_d.sts[BIT_GBL] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign sts_o = ev_q.sts;
    assign en_o  = ev_q.en;
    assign sci_o = |(ev_q.en & ev_q.sts & SCI_SRC_MASK);

    // R4: a clearing byte on lane 0 drops the timer flag when no set competes
    p_clear_lane0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we[0] && lane_wd[BIT_TMR] && !set_tmr) |=> !sts_o[BIT_TMR]);

    // R4: only the three source positions ever hold a flag
    p_sts_confined_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_o & ~SCI_SRC_MASK) == '0);

    // R5: writing only the low enable lane leaves the high lane alone
    p_en_lane_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we[2] && !lane_we[3]) |=> (en_o[15:8] == $past(en_o[15:8])));

    // R10: set strobes win over any clear in the same cycle
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_pwr || set_gbl) |=>
            ((!$past(set_pwr) || sts_o[BIT_PWR]) && (!$past(set_gbl) || sts_o[BIT_GBL])));

endmodule

// File: rtl/pmtick_sci_top.sv
module pmtick_sci_top
    import pmtick_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] EVT_BASE = 16'h0400,
    parameter logic [ADDR_W-1:0] TMR_BASE = 16'h0408,
    parameter int                TMR_W    = 32,
    parameter longint            REF_HZ   = 50_000_000,
    parameter longint            TMR_HZ   = 3_579_545
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              set_pwrbtn,
    input  logic              set_global,
    output logic              sci
);
    localparam logic [63:0] SCALE = (64'(TMR_HZ) << 32) / 64'(REF_HZ);

    logic [TMR_W-1:0] tmr_count;
    logic             tmr_flip;
    logic [3:0]       lane_we;
    logic [31:0]      lane_wd;
    logic             evt_rd_hit, tmr_rd_hit;
    logic [1:0]       evt_off;
    logic [EVT_W-1:0] evt_sts, evt_en;
    logic [31:0]      evt_word, evt_shift;

    pmtick_rate_gen #(.TMR_W(TMR_W), .SCALE(SCALE)) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_o    (tmr_count),
        .msb_flip_o (tmr_flip)
    );

    pmtick_port #(.ADDR_W(ADDR_W), .EVT_BASE(EVT_BASE), .TMR_BASE(TMR_BASE)) u_port (
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_wdata  (bus_wdata),
        .lane_we    (lane_we),
        .lane_wd    (lane_wd),
        .evt_rd_hit (evt_rd_hit),
        .evt_off    (evt_off),
        .tmr_rd_hit (tmr_rd_hit)
    );

    pmtick_event_regs u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_we (lane_we),
        .lane_wd (lane_wd),
        .set_tmr (tmr_flip),
        .set_pwr (set_pwrbtn),
        .set_gbl (set_global),
        .sts_o   (evt_sts),
        .en_o    (evt_en),
        .sci_o   (sci)
    );

    always_comb begin
        evt_word  = {evt_en, evt_sts};
        evt_shift = evt_word >> {evt_off, 3'b000};
        case (acc_size_e'(bus_size))
            SZ_BYTE: evt_shift = evt_shift & 32'h0000_00FF;
            SZ_HALF: evt_shift = evt_shift & 32'h0000_FFFF;
            default: ;
        endcase
        if (evt_rd_hit)      bus_rdata = evt_shift;
        else if (tmr_rd_hit) bus_rdata = 32'(tmr_count);
        else                 bus_rdata = '0;
    end

    // R3: any change of the timer's top bit leaves the timer flag set
    p_msb_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_count[TMR_W-1] != $past(tmr_count[TMR_W-1])) |-> evt_sts[BIT_TMR]);

endmodule

// File: tb/sim_pmtick_sci_top.sv
module sim_pmtick_sci_top;
    localparam logic [15:0] EVT = 16'h0400;
    localparam logic [15:0] TMR = 16'h0408;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        set_pwrbtn = 1'b0, set_global = 1'b0;
    logic        sci;
    logic        last_sci;
    int          n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    pmtick_sci_top #(.TMR_W(10), .REF_HZ(50_000_000), .TMR_HZ(25_000_000)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .set_pwrbtn(set_pwrbtn), .set_global(set_global),
        .sci(sci)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
        set_pwrbtn = 1'b0; set_global = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = sz;
        #1;
        d = bus_rdata;
        last_sci = sci;
        bus_valid = 1'b0;
    endtask

    task automatic pulse_sets(input logic p, input logic g);
        @(negedge clk);
        set_pwrbtn = p; set_global = g;
        @(negedge clk);
        set_pwrbtn = 1'b0; set_global = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(EVT, 2'd2, d);  chk("R1 event word after reset", d, 32'h0);
        chk("R1 sci after reset", {31'b0, last_sci}, 32'h0);
        rd(TMR, 2'd2, d);  chk("R1 timer near zero after reset", {31'b0, d < 32'd4}, 32'h1);
    endtask

    task automatic t_rate();
        logic [31:0] a, b;
        do_reset();
        rd(TMR, 2'd2, a);
        repeat (99) @(negedge clk);
        rd(TMR, 2'd2, b);
        chk("R2 timer gain over 100 clocks", b - a, 32'd50);
    endtask

    task automatic t_msb();
        logic [31:0] t;
        int bad;
        do_reset();
        wr(EVT + 16'd2, 2'd0, 32'h01);
        bad = 0; t = 0;
        for (int i = 0; i < 1300; i++) begin
            rd(TMR, 2'd2, t);
            if (last_sci != (t >= 32'd512)) bad++;
            if (t >= 32'd512) break;
        end
        chk("R3 sci low before top bit rises", bad, 0);
        chk("R3 first count with flag set", t, 32'd512);
        wr(EVT, 2'd0, 32'h01);
        rd(EVT, 2'd0, t);
        chk("R4 timer flag cleared by write", t & 32'h1, 32'h0);
        bad = 0;
        for (int i = 0; i < 1300; i++) begin
            rd(TMR, 2'd2, t);
            if (last_sci != (t < 32'd512)) bad++;
            if (t < 32'd512) break;
        end
        chk("R3 sci low until wrap", bad, 0);
        chk("R3 wrap reaches zero with flag", t, 32'd0);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        do_reset();
        pulse_sets(1'b1, 1'b1);
        rd(EVT, 2'd1, d);           chk("R10 strobes set bits 5 and 8", d, 32'h0120);
        wr(EVT + 16'd1, 2'd0, 32'h00);
        rd(EVT, 2'd1, d);           chk("R4 zero byte clears nothing", d, 32'h0120);
        wr(EVT, 2'd0, 32'h20);
        rd(EVT, 2'd1, d);           chk("R4 lane 0 clears bit 5 only", d, 32'h0100);
        wr(EVT + 16'd1, 2'd0, 32'h01);
        rd(EVT, 2'd1, d);           chk("R4 lane 1 clears bit 8", d, 32'h0000);
        wr(EVT + 16'd2, 2'd1, 32'hFFFF);
        rd(EVT, 2'd1, d);           chk("R4 unused status bits stay zero", d, 32'h0000);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        do_reset();
        @(negedge clk);
        set_global = 1'b1;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = EVT + 16'd1; bus_size = 2'd0;
        bus_wdata = 32'h01;
        @(negedge clk);
        set_global = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
        rd(EVT, 2'd1, d);           chk("R10 set beats same-cycle clear", d, 32'h0100);
    endtask

    task automatic t_enable_lanes();
        logic [31:0] d;
        do_reset();
        wr(EVT + 16'd2, 2'd0, 32'h5A);
        rd(EVT + 16'd2, 2'd1, d);   chk("R5 low enable lane", d, 32'h005A);
        wr(EVT + 16'd3, 2'd0, 32'hC3);
        rd(EVT + 16'd2, 2'd1, d);   chk("R5 high lane keeps low", d, 32'hC35A);
        wr(EVT + 16'd2, 2'd0, 32'h11);
        rd(EVT + 16'd2, 2'd1, d);   chk("R5 low lane keeps high", d, 32'hC311);
    endtask

    task automatic t_multibyte();
        logic [31:0] d;
        do_reset();
        pulse_sets(1'b1, 1'b1);
        wr(EVT + 16'd1, 2'd2, 32'h4433_2201);
        rd(EVT, 2'd2, d);           chk("R6 split write from offset 1", d, 32'h3322_0020);
        rd(EVT + 16'd2, 2'd0, d);   chk("R7 byte read offset 2", d, 32'h22);
        rd(EVT + 16'd1, 2'd1, d);   chk("R7 half read offset 1", d, 32'h2200);
        rd(EVT + 16'd3, 2'd2, d);   chk("R7 word read offset 3", d, 32'h33);
        rd(EVT, 2'd3, d);           chk("R7 size code 3 is word", d, 32'h3322_0020);
        wr(EVT, 2'd1, 32'h0000_0120);
        rd(EVT, 2'd2, d);           chk("R6 half write clears both lanes", d, 32'h3322_0000);
    endtask

    task automatic t_timer_ro();
        logic [31:0] d;
        do_reset();
        wr(TMR, 2'd2, 32'hFFFF_FFFF);
        rd(TMR, 2'd2, d);           chk("R8 timer write ignored", {31'b0, d < 32'd16}, 32'h1);
        rd(EVT, 2'd2, d);           chk("R8 timer write left event regs", d, 32'h0);
        repeat (10) @(negedge clk);
        rd(TMR, 2'd0, d);           chk("R8 byte read of timer is zero", d, 32'h0);
        rd(TMR, 2'd1, d);           chk("R8 half read of timer is zero", d, 32'h0);
    endtask

    task automatic t_sci();
        logic [31:0] d;
        do_reset();
        wr(EVT + 16'd2, 2'd1, 32'hFEDE);
        pulse_sets(1'b1, 1'b1);
        rd(EVT, 2'd1, d);
        chk("R9 non-source enables keep sci low", {31'b0, last_sci}, 32'h0);
        wr(EVT + 16'd2, 2'd1, 32'h0020);
        rd(EVT, 2'd1, d);
        chk("R9 enabled power flag raises sci", {31'b0, last_sci}, 32'h1);
        wr(EVT + 16'd2, 2'd1, 32'h0000);
        rd(EVT, 2'd1, d);
        chk("R9 sci drops with enable", {31'b0, last_sci}, 32'h0);
        wr(EVT + 16'd2, 2'd1, 32'h0100);
        rd(EVT, 2'd1, d);
        chk("R9 enabled global flag raises sci", {31'b0, last_sci}, 32'h1);
        wr(EVT + 16'd1, 2'd0, 32'h01);
        rd(EVT, 2'd1, d);
        chk("R9 sci drops with status", {31'b0, last_sci}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_rate();
        t_msb();
        t_w1c();
        t_set_wins();
        t_enable_lanes();
        t_multibyte();
        t_timer_ro();
        t_sci();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule